// File: doc/BRIEF.md
# Display Buffer Scan Address Generator

This block produces the byte addresses used by display refresh to pull data out of a graphics memory window of at most 4 MB. It runs three fetch pointers at once: one for the uncompressed frame buffer, one for the compressed display buffer, and one for the cursor pattern. It also presents the programmed video buffer start address and the current sub-DWORD pixel offset. Every pointer is a 22-bit offset inside the window. The upper address bits come from a graphics base that is aligned to 4 MB and supplied on a port.

Software loads a small configuration bank through a write port. The bank holds the start offsets, a line-to-line delta for each scan-line buffer and the number of active DWORDs for each buffer per line. The display timing logic gives two strobes. The frame strobe reloads every pointer. The line strobe moves each scan-line buffer on by its delta. Fetch-accept inputs step a pointer by one DWORD at a time.

The frame buffer start offset is split into two parts. Its DWORD-level part is held back until the next frame strobe, so panning changes only between frames. Its low 4-bit pixel part takes effect at once. While any part of the live frame buffer offset is nonzero, compressed-buffer fetch requests are blocked.

Top module: `disp_scan_addr`

## Requirements
- R1: After reset, every pointer and every configuration field is zero. The pixel offset is zero, each address output equals the base in bits 31:22 with zeros below, and both line-done flags are 1 because the active counts are zero.
- R2: A write with `cfg_sel`=0 puts `cfg_wdata[21:4]` into a pending frame buffer start offset. `fb_addr` keeps its value until a `frame_start` cycle. From the cycle after that strobe, `fb_addr[21:0]` equals the pending offset with bits 3:0 zero.
- R3: If a `cfg_sel`=0 write and `frame_start` fall in the same cycle, the frame reloads from the offset written earlier. The new value waits for the following `frame_start`.
- R4: A `cfg_sel`=0 write sets `pix_ofs` to `cfg_wdata[3:0]` from the next cycle, with no dependence on `frame_start`.
- R5: Within a line, each cycle with a take strobe moves the buffer's fetch address on by 4, as long as its line-done flag is 0. The flag reads 1 once the number of takes since the line began equals the programmed active count. Takes made while the flag is 1 do not change the address. The active counts are written with `cfg_sel`=5 (frame buffer) and `cfg_sel`=7 (compressed buffer), from bits 9:0.
- R6: On `line_start` (with no `frame_start`), a scan-line buffer's line pointer moves on by its delta. The fetch address jumps to the new line pointer and the take count clears. The deltas are written with `cfg_sel`=4 (frame buffer) and `cfg_sel`=6 (compressed buffer), from bits 21:0. `frame_start` takes priority over `line_start`, and `line_start` takes priority over a take.
- R7: A `cfg_sel`=1 write sets the compressed buffer start offset to `cfg_wdata[21:4]` with bits 3:0 forced to zero. `frame_start` reloads the compressed pointer from it.
- R8: A `cfg_sel`=2 write sets the cursor start offset to `cfg_wdata[21:2]` with bits 1:0 forced to zero. `frame_start` reloads `cur_addr` from it. Each `cur_take` otherwise adds 4, and there is no line delta.
- R9: A `cfg_sel`=3 write sets the video start offset to `cfg_wdata[21:4]` with bits 3:0 forced to zero. `vid_addr` shows it, below the base, from the next cycle.
- R10: `cb_req_ok` equals `cb_req` only while the live frame buffer offset and the pixel offset are both zero. Otherwise it is 0.
- R11: All pointer arithmetic wraps modulo 4 MB inside bits 21:0. Bits 31:22 of every address output always equal `gfx_base_hi`.
- R12: Bits 31:22 of `cfg_wdata` have no effect on any stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gfx_base_hi | input | 10 | Graphics base address bits 31:22 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_wdata | input | 32 | Configuration write data |
| frame_start | input | 1 | Start of frame scan strobe |
| line_start | input | 1 | Start of next scan line strobe |
| fb_take | input | 1 | Frame buffer DWORD fetch accepted |
| cb_take | input | 1 | Compressed buffer DWORD fetch accepted |
| cur_take | input | 1 | Cursor DWORD fetch accepted |
| cb_req | input | 1 | Compressed buffer fetch request in |
| fb_addr | output | 32 | Frame buffer fetch address |
| cb_addr | output | 32 | Compressed buffer fetch address |
| cur_addr | output | 32 | Cursor fetch address |
| vid_addr | output | 32 | Video buffer start address |
| pix_ofs | output | 4 | Current pixel offset |
| fb_line_done | output | 1 | Frame buffer line has issued its active count |
| cb_line_done | output | 1 | Compressed buffer line has issued its active count |
| cb_req_ok | output | 1 | Compressed request allowed through |

## Verification
The scan walkers are run under four patterns, each aimed at a different fault. A take on every cycle with a short active count shows whether the done flag stops the fetch pointer at the right DWORD. Alternating takes and line strobes with a zero frame offset expose any confusion between the line pointer and the fetch pointer, and they also show the compressed request passing through. A long pseudo-random stretch that also rewrites every configuration field mixes strobes, writes and takes in the same cycle, which tests the priority order and the deferred loading of the frame offset. Directed cases finish the job: a write on the frame strobe cycle, a start offset just below the top of the window, a line delta that wraps past the window end, and write data with the reserved upper bits set.

// File: rtl/disp_scan_addr_pkg.sv
package disp_scan_addr_pkg;
  parameter int ADDR_W = 32;
  parameter int APER_W = 22;
  parameter int CNT_W  = 10;
  parameter int PIX_W  = 4;
  localparam int BASE_W = ADDR_W - APER_W;
  localparam int NWALK  = 2;

  typedef enum logic [2:0] {
    SEL_FB_OFS  = 3'd0,
    SEL_CB_OFS  = 3'd1,
    SEL_CUR_OFS = 3'd2,
    SEL_VID_OFS = 3'd3,
    SEL_FB_DLT  = 3'd4,
    SEL_FB_CNT  = 3'd5,
    SEL_CB_DLT  = 3'd6,
    SEL_CB_CNT  = 3'd7
  } cfg_sel_e;
endpackage

// File: rtl/dsa_cfg_bank.sv
module dsa_cfg_bank
  import disp_scan_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [APER_W-1:0] wr_data,
  input  logic              frame_start,
  output logic [APER_W-1:0] fb_pend_ofs,
  output logic [APER_W-1:0] fb_live_ofs,
  output logic [PIX_W-1:0]  pix_ofs,
  output logic [APER_W-1:0] cb_ofs,
  output logic [APER_W-1:0] cur_ofs,
  output logic [APER_W-1:0] vid_ofs,
  output logic [APER_W-1:0] fb_dlt,
  output logic [APER_W-1:0] cb_dlt,
  output logic [CNT_W-1:0]  fb_cnt,
  output logic [CNT_W-1:0]  cb_cnt
);
  localparam int HI16 = APER_W - 4;
  localparam int HI4  = APER_W - 2;

  logic [HI16-1:0]   pend_q, pend_d, live_q, live_d, cb_q, cb_d, vid_q, vid_d;
  logic [HI4-1:0]    cur_q, cur_d;
  logic [PIX_W-1:0]  pix_q, pix_d;
  logic [APER_W-1:0] fdl_q, fdl_d, cdl_q, cdl_d;
  logic [CNT_W-1:0]  fcn_q, fcn_d, ccn_q, ccn_d;
  logic              upd_en;

  assign upd_en = wr_en | frame_start;

  always_comb begin
    pend_d = pend_q; live_d = live_q; cb_d = cb_q; vid_d = vid_q;
    cur_d = cur_q; pix_d = pix_q; fdl_d = fdl_q; cdl_d = cdl_q;
    fcn_d = fcn_q; ccn_d = ccn_q;
    if (frame_start) live_d = pend_q;
    if (wr_en) begin
      unique case (cfg_sel_e'(wr_sel))
        SEL_FB_OFS: begin
          pend_d = wr_data[APER_W-1:4];
          pix_d  = wr_data[PIX_W-1:0];
        end
        SEL_CB_OFS:  cb_d  = wr_data[APER_W-1:4];
        SEL_CUR_OFS: cur_d = wr_data[APER_W-1:2];
        SEL_VID_OFS: vid_d = wr_data[APER_W-1:4];
        SEL_FB_DLT:  fdl_d = wr_data;
        SEL_FB_CNT:  fcn_d = wr_data[CNT_W-1:0];
        SEL_CB_DLT:  cdl_d = wr_data;
        SEL_CB_CNT:  ccn_d = wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0; live_q <= '0; cb_q <= '0; vid_q <= '0; cur_q <= '0;
      pix_q <= '0; fdl_q <= '0; cdl_q <= '0; fcn_q <= '0; ccn_q <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d; live_q <= live_d; cb_q <= cb_d; vid_q <= vid_d;
      cur_q <= cur_d; pix_q <= pix_d; fdl_q <= fdl_d; cdl_q <= cdl_d;
      fcn_q <= fcn_d; ccn_q <= ccn_d;
    end
  end

  assign fb_pend_ofs = {pend_q, 4'b0};
  assign fb_live_ofs = {live_q, 4'b0};
  assign pix_ofs     = pix_q;
  assign cb_ofs      = {cb_q, 4'b0};
  assign cur_ofs     = {cur_q, 2'b0};
  assign vid_ofs     = {vid_q, 4'b0};
  assign fb_dlt      = fdl_q;
  assign cb_dlt      = cdl_q;
  assign fb_cnt      = fcn_q;
  assign cb_cnt      = ccn_q;

  // R2
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> fb_live_ofs == $past(fb_pend_ofs));
  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(fb_live_ofs));
endmodule

// File: rtl/dsa_line_walker.sv
module dsa_line_walker
  import disp_scan_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              take,
  input  logic [APER_W-1:0] start_ofs,
  input  logic [APER_W-1:0] line_dlt,
  input  logic [CNT_W-1:0]  act_cnt,
  output logic [APER_W-1:0] fetch_ofs,
  output logic              line_done
);
  localparam logic [APER_W-1:0] DW_STEP = APER_W'(4);

  logic [APER_W-1:0] line_q, line_d, addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              step_en, adv_en;

  assign line_done = (cnt_q == act_cnt);
  assign step_en   = take & ~line_done;
  assign adv_en    = frame_start | line_start | step_en;

  always_comb begin
    line_d = line_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (frame_start) begin
      line_d = start_ofs;
      addr_d = start_ofs;
      cnt_d  = '0;
    end else if (line_start) begin
      line_d = line_q + line_dlt;
      addr_d = line_q + line_dlt;
      cnt_d  = '0;
    end else if (step_en) begin
      addr_d = addr_q + DW_STEP;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (adv_en) begin
      line_q <= line_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign fetch_ofs = addr_q;

  // R5
  dword_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !line_done && !frame_start && !line_start)
      |=> fetch_ofs == $past(fetch_ofs) + DW_STEP);
  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !frame_start && !line_start) |=> $stable(fetch_ofs));
  // R6
  line_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start) |=> cnt_q == '0);
endmodule

// File: rtl/disp_scan_addr.sv
module disp_scan_addr
  import disp_scan_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] gfx_base_hi,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              fb_take,
  input  logic              cb_take,
  input  logic              cur_take,
  input  logic              cb_req,
  output logic [ADDR_W-1:0] fb_addr,
  output logic [ADDR_W-1:0] cb_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] vid_addr,
  output logic [PIX_W-1:0]  pix_ofs,
  output logic              fb_line_done,
  output logic              cb_line_done,
  output logic              cb_req_ok
);
  localparam logic [APER_W-1:0] CUR_STEP = APER_W'(4);

  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [ADDR_W-APER_W-1:0] wdata_unused;
  assign wdata_unused = cfg_wdata[ADDR_W-1:APER_W];

  logic [APER_W-1:0] fb_pend, fb_live, cb_ofs, cur_ofs, vid_ofs;
  logic [APER_W-1:0] fb_dlt, cb_dlt;
  logic [CNT_W-1:0]  fb_cnt, cb_cnt;

  dsa_cfg_bank u_cfg (
    .clk(clk), .rst_n(rst_s_n), .wr_en(cfg_wr), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata[APER_W-1:0]), .frame_start(frame_start),
    .fb_pend_ofs(fb_pend), .fb_live_ofs(fb_live), .pix_ofs(pix_ofs),
    .cb_ofs(cb_ofs), .cur_ofs(cur_ofs), .vid_ofs(vid_ofs),
    .fb_dlt(fb_dlt), .cb_dlt(cb_dlt), .fb_cnt(fb_cnt), .cb_cnt(cb_cnt)
  );

  logic [APER_W-1:0] w_start [NWALK];
  logic [APER_W-1:0] w_dlt   [NWALK];
  logic [CNT_W-1:0]  w_cnt   [NWALK];
  logic              w_take  [NWALK];
  logic [APER_W-1:0] w_addr  [NWALK];
  logic              w_done  [NWALK];

  assign w_start[0] = fb_pend; assign w_dlt[0] = fb_dlt;
  assign w_cnt[0]   = fb_cnt;  assign w_take[0] = fb_take;
  assign w_start[1] = cb_ofs;  assign w_dlt[1] = cb_dlt;
  assign w_cnt[1]   = cb_cnt;  assign w_take[1] = cb_take;

  for (genvar g = 0; g < NWALK; g++) begin : g_walk
    dsa_line_walker u_walk (
      .clk(clk), .rst_n(rst_s_n), .frame_start(frame_start),
      .line_start(line_start), .take(w_take[g]), .start_ofs(w_start[g]),
      .line_dlt(w_dlt[g]), .act_cnt(w_cnt[g]),
      .fetch_ofs(w_addr[g]), .line_done(w_done[g])
    );
  end

  logic [APER_W-1:0] cur_q, cur_d;
  logic              cur_en;
  assign cur_en = frame_start | cur_take;
  always_comb begin
    cur_d = cur_q;
    if (frame_start)   cur_d = cur_ofs;
    else if (cur_take) cur_d = cur_q + CUR_STEP;
  end
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  logic fb_ofs_zero;
  assign fb_ofs_zero = (fb_live == '0) && (pix_ofs == '0);

  assign fb_addr      = {gfx_base_hi, w_addr[0]};
  assign cb_addr      = {gfx_base_hi, w_addr[1]};
  assign cur_addr     = {gfx_base_hi, cur_q};
  assign vid_addr     = {gfx_base_hi, vid_ofs};
  assign fb_line_done = w_done[0];
  assign cb_line_done = w_done[1];
  assign cb_req_ok    = cb_req & fb_ofs_zero;

  // R8
  cur_step_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cur_take && !frame_start) |=> cur_q == $past(cur_q) + CUR_STEP);
  // R8
  cur_reload_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    frame_start |=> cur_q == $past(cur_ofs));
endmodule

// File: tb/disp_scan_addr_tb_top.sv
`timescale 1ns/1ps
module disp_scan_addr_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  base = 10'h2A5;
  logic        we = 0, fs = 0, ls = 0, ft = 0, ct = 0, kt = 0, creq = 0;
  logic [2:0]  sel = 0;
  logic [31:0] wd = 0;
  logic [31:0] fb_addr, cb_addr, cur_addr, vid_addr;
  logic [3:0]  pix;
  logic        fb_done, cb_done, cb_ok;

  always #2 clk = ~clk;

  disp_scan_addr dut_i (
    .clk(clk), .rst_n(rst_n), .gfx_base_hi(base), .cfg_wr(we),
    .cfg_sel(sel), .cfg_wdata(wd), .frame_start(fs), .line_start(ls),
    .fb_take(ft), .cb_take(ct), .cur_take(kt), .cb_req(creq),
    .fb_addr(fb_addr), .cb_addr(cb_addr), .cur_addr(cur_addr),
    .vid_addr(vid_addr), .pix_ofs(pix), .fb_line_done(fb_done),
    .cb_line_done(cb_done), .cb_req_ok(cb_ok)
  );

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [21:0] m_pend, m_live, m_cb, m_cur, m_vid, m_curp;
  logic [3:0]  m_pix;
  logic [21:0] m_dlt [2], m_line [2], m_fetch [2];
  logic [9:0]  m_cnt [2], m_n [2];
  bit s1 = 0, s2 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_live = 0; m_cb = 0; m_cur = 0; m_vid = 0; m_curp = 0; m_pix = 0;
      for (int k = 0; k < 2; k++) begin
        m_dlt[k] = 0; m_line[k] = 0; m_fetch[k] = 0; m_cnt[k] = 0; m_n[k] = 0;
      end
      s1 = 0; s2 = 0;
    end else begin
      if (s2) begin
        for (int k = 0; k < 2; k++) begin
          logic tk;
          logic [21:0] st;
          tk = (k == 0) ? ft : ct;
          st = (k == 0) ? m_pend : m_cb;
          if (fs) begin
            m_line[k] = st; m_fetch[k] = st; m_n[k] = 0;
          end else if (ls) begin
            m_line[k] = m_line[k] + m_dlt[k]; m_fetch[k] = m_line[k]; m_n[k] = 0;
          end else if (tk && m_n[k] != m_cnt[k]) begin
            m_fetch[k] = m_fetch[k] + 22'd4; m_n[k] = m_n[k] + 10'd1;
          end
        end
        if (fs) m_curp = m_cur;
        else if (kt) m_curp = m_curp + 22'd4;
        if (fs) m_live = m_pend;
        if (we) begin
          case (sel)
            3'd0: begin m_pend = {wd[21:4], 4'h0}; m_pix = wd[3:0]; end
            3'd1: m_cb  = {wd[21:4], 4'h0};
            3'd2: m_cur = {wd[21:2], 2'b00};
            3'd3: m_vid = {wd[21:4], 4'h0};
            3'd4: m_dlt[0] = wd[21:0];
            3'd5: m_cnt[0] = wd[9:0];
            3'd6: m_dlt[1] = wd[21:0];
            default: m_cnt[1] = wd[9:0];
          endcase
        end
      end
      s2 = s1; s1 = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 fb_addr", fb_addr, {base, m_fetch[0]});
      chk("R7 cb_addr", cb_addr, {base, m_fetch[1]});
      chk("R8 cur_addr", cur_addr, {base, m_curp});
      chk("R9 vid_addr", vid_addr, {base, m_vid});
      chk("R4 pix_ofs", {28'h0, pix}, {28'h0, m_pix});
      chk("R5 fb_line_done", {31'h0, fb_done}, {31'h0, m_n[0] == m_cnt[0]});
      chk("R6 cb_line_done", {31'h0, cb_done}, {31'h0, m_n[1] == m_cnt[1]});
    end
  end

  always @(negedge clk) begin
    #1.5;
    if (cmp_on)
      chk("R10 cb_req_ok", {31'h0, cb_ok}, {31'h0, creq && m_live == 0 && m_pix == 0});
  end

  task automatic drive(input logic f, input logic l, input logic a, input logic b,
                       input logic c, input logic w, input logic [2:0] s,
                       input logic [31:0] d);
    @(negedge clk); #1;
    fs = f; ls = l; ft = a; ct = b; kt = c; we = w; sel = s; wd = d;
  endtask

  task automatic idle(); drive(0, 0, 0, 0, 0, 0, 3'd0, 32'h0); endtask
  task automatic wr(input logic [2:0] s, input logic [31:0] d); drive(0, 0, 0, 0, 0, 1, s, d); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (4) @(posedge clk);
    cmp_on = 1;
    @(negedge clk); rst_n = 1;
    repeat (4) idle();
    // R1 reset state
    chk("R1 fb_addr reset", fb_addr, {base, 22'h0});
    chk("R1 line_done reset", {31'h0, fb_done & cb_done}, 32'h1);
    chk("R1 pix reset", {28'h0, pix}, 32'h0);

    wr(3'd4, 32'h500); wr(3'd5, 32'd5); wr(3'd6, 32'h140); wr(3'd7, 32'd3);
    wr(3'd1, 32'h0002_0007); wr(3'd2, 32'h0000_3003); wr(3'd3, 32'h0004_001F);
    wr(3'd0, 32'h0001_2348);
    idle();
    chk("R4 pix immediate", {28'h0, pix}, 32'h8);
    chk("R2 fb_addr before frame", fb_addr, {base, 22'h0});
    drive(1, 0, 0, 0, 0, 0, 3'd0, 0); idle();
    chk("R2 fb_addr after frame", fb_addr, {base, 22'h12340});
    chk("R9 vid aligned", vid_addr, {base, 22'h40010});

    // pattern A: take every cycle, nonzero frame offset
    creq = 1;
    for (int i = 0; i < 40; i++)
      drive(0, (i % 10) == 9, 1, i[0], (i % 3) == 0, 0, 3'd0, 0);
    // pattern B: zero frame offset, alternating takes and lines
    wr(3'd0, 32'h0); drive(1, 0, 0, 0, 0, 0, 3'd0, 0);
    for (int i = 0; i < 40; i++) begin
      creq = i[1];
      drive(0, i[2] & i[0], ~i[0], i[0], i[0], 0, 3'd0, 0);
    end
    // pattern C: pseudo-random mix including config writes
    lf = 16'hACE1;
    for (int i = 0; i < 500; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      creq = lf[8];
      drive((i % 97) == 96, lf[7:4] == 0, lf[0], lf[3], lf[5], lf[11:9] == 0,
            lf[14:12], {lf, lf ^ 16'h5A3C});
    end

    // R3 write on the frame strobe cycle
    wr(3'd0, 32'h100); drive(1, 0, 0, 0, 0, 0, 3'd0, 0);
    drive(1, 0, 0, 0, 0, 1, 3'd0, 32'h200); idle();
    chk("R3 old offset applied", fb_addr, {base, 22'h100});
    drive(1, 0, 0, 0, 0, 0, 3'd0, 0); idle();
    chk("R3 new offset next frame", fb_addr, {base, 22'h200});

    // R11 wrap at top of window, R5 count, R6 delta wrap
    wr(3'd4, 32'h30); wr(3'd5, 32'd8); wr(3'd0, 32'h003F_FFF0);
    drive(1, 0, 0, 0, 0, 0, 3'd0, 0);
    repeat (4) drive(0, 0, 1, 0, 0, 0, 3'd0, 0);
    idle();
    chk("R11 fetch wraps", fb_addr, {base, 22'h0});
    chk("R5 not yet done", {31'h0, fb_done}, 32'h0);
    repeat (6) drive(0, 0, 1, 0, 0, 0, 3'd0, 0);
    idle();
    chk("R5 stops at count", fb_addr, {base, 22'h10});
    chk("R5 done after count", {31'h0, fb_done}, 32'h1);
    drive(0, 1, 0, 0, 0, 0, 3'd0, 0); idle();
    chk("R6 line delta wraps", fb_addr, {base, 22'h20});

    // R12 reserved upper data bits ignored
    wr(3'd2, 32'hFFC0_0104); drive(1, 0, 0, 0, 0, 0, 3'd0, 0); idle();
    chk("R12 cur upper bits ignored", cur_addr, {base, 22'h104});
    repeat (3) idle();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule